// File: doc/BRIEF.md
# CAN Fault-Confinement State Classifier

The block watches the error-flag byte that a CAN controller exposes and, each time a strobe marks the byte as fresh, turns it into the node's fault-confinement state: error-active, error-warning, error-passive or bus-off. With the state it records a short reason code that tells whether a transmit-side or a receive-side condition put the node there, and whether a receive overrun was reported. Three saturating statistic counters track escalations into warning, escalations into passive, and receive-buffer overruns.

Entering bus-off raises a one-cycle event. When automatic restart is off, bus-off also raises a halt output and every later strobe is ignored until a restart pulse arrives. A restart puts the node back in error-active and raises a one-cycle restarted event. The error counters of the CAN protocol are computed elsewhere; this block only interprets their summary flags.

Top module: `can_fault_monitor`

## Requirements
- R1: On an accepted strobe the next state comes from the flag byte by fixed priority: bit5 (transmit bus-off) gives bus-off (code 3); otherwise bit4 (transmit passive) or bit3 (receive passive) gives passive (code 2); otherwise bit2 (transmit warning) or bit1 (receive warning) gives warning (code 1); otherwise error-active (code 0). Bit0 (summary warning) alone leaves the state error-active.
- R2: The reason output is {overflow, source}: source is 3 for bus-off, 1 when the winning flag is bit4 or bit2, 2 when it is bit3 or bit1, 0 for error-active; overflow is 1 when the error-interrupt qualifier is high and bit6 or bit7 is set.
- R3: The warning statistic rises by one on every accepted transition from error-active into warning, passive or bus-off.
- R4: The passive statistic rises by one on every accepted transition from error-active or warning into passive or bus-off, so a direct jump from error-active raises both statistics.
- R5: With the qualifier high, an accepted strobe adds one to the overrun statistic for bit6 (buffer 0) and one for bit7 (buffer 1), two when both are set; with the qualifier low it adds nothing.
- R6: All statistics are 16 bits wide and hold at 65535 instead of wrapping.
- R7: An accepted strobe that yields bus-off while auto-restart is low sets the halt output; while halted, strobes change neither state, reason nor statistics.
- R8: With auto-restart high, bus-off does not halt and later strobes keep being classified.
- R9: A restart pulse sets the state to error-active, clears the reason and halt, and raises the restarted output for exactly one cycle; it wins over a strobe in the same cycle, which is dropped.
- R10: The bus-off event is high for one cycle after a strobe moves the state from any other state into bus-off, and not on a strobe that finds the state already bus-off.
- R11: After reset the state is error-active, the reason is 0, halt and both events are low and all statistics are zero.
- R12: All results appear on the clock edge that samples the strobe; without a strobe or restart every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flags_i | input | 8 | Error-flag byte from the controller |
| sample_i | input | 1 | Strobe: flag byte is valid this cycle |
| err_irq_i | input | 1 | Error-interrupt qualifier for overrun counting |
| auto_restart_i | input | 1 | High: bus-off does not halt |
| restart_i | input | 1 | Restart pulse |
| state_o | output | 2 | Fault-confinement state (0 active, 1 warning, 2 passive, 3 bus-off) |
| reason_o | output | 3 | {overflow, source} reason code |
| halt_o | output | 1 | Halted in bus-off awaiting restart |
| busoff_evt_o | output | 1 | One-cycle bus-off entry event |
| restarted_o | output | 1 | One-cycle restarted event |
| warn_cnt_o | output | 16 | Escalations into warning or worse |
| passive_cnt_o | output | 16 | Escalations into passive or worse |
| ovr_cnt_o | output | 16 | Receive-buffer overruns |

## Verification
Every result of this block, the state, reason, halt flag, both events and all three statistics, is registered once, so each is due on the first rising edge after the strobe or restart is presented. The bench drives inputs on the falling edge, advances its own model of the same edge, and compares every output on the following falling edge, exactly one edge later. Cycles with no strobe are compared too, so holding behaviour is checked on the same schedule.

// File: rtl/canfc_pkg.sv
package canfc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_WARN    = 2'd1,
    FC_PASSIVE = 2'd2,
    FC_BUSOFF  = 2'd3
  } fc_state_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_TX     = 2'd1,
    SRC_RX     = 2'd2,
    SRC_BUSOFF = 2'd3
  } fc_src_e;

  localparam int FLAG_W      = 8;
  localparam int B_RX_WARN   = 1;
  localparam int B_TX_WARN   = 2;
  localparam int B_RX_PASS   = 3;
  localparam int B_TX_PASS   = 4;
  localparam int B_TX_BUSOFF = 5;
  localparam int B_OVR0      = 6;
  localparam int B_OVR1      = 7;
  localparam int REASON_W    = 3;
  localparam int INC_W       = 2;
  localparam int N_STATS     = 3;
endpackage

// File: rtl/canfc_classify.sv
module canfc_classify
  import canfc_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              irq_i,
  output fc_state_e         state_o,
  output fc_src_e           src_o,
  output logic [INC_W-1:0]  ovr_n_o,
  output logic              ovf_o
);
  always_comb begin
    if (flags_i[B_TX_BUSOFF]) begin
      state_o = FC_BUSOFF;
      src_o   = SRC_BUSOFF;
    end else if (flags_i[B_TX_PASS]) begin
      state_o = FC_PASSIVE;
      src_o   = SRC_TX;
    end else if (flags_i[B_RX_PASS]) begin
      state_o = FC_PASSIVE;
      src_o   = SRC_RX;
    end else if (flags_i[B_TX_WARN]) begin
      state_o = FC_WARN;
      src_o   = SRC_TX;
    end else if (flags_i[B_RX_WARN]) begin
      state_o = FC_WARN;
      src_o   = SRC_RX;
    end else begin
      state_o = FC_ACTIVE;
      src_o   = SRC_NONE;
    end
  end

  always_comb begin
    if (irq_i) begin
      ovr_n_o = {1'b0, flags_i[B_OVR0]} + {1'b0, flags_i[B_OVR1]};
      ovf_o   = flags_i[B_OVR0] | flags_i[B_OVR1];
    end else begin
      ovr_n_o = '0;
      ovf_o   = 1'b0;
    end
  end
endmodule

// File: rtl/canfc_ctrl.sv
module canfc_ctrl
  import canfc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_i,
  input  logic                restart_i,
  input  logic                auto_restart_i,
  input  fc_state_e           new_state_i,
  input  fc_src_e             src_i,
  input  logic                ovf_i,
  output fc_state_e           state_o,
  output logic [REASON_W-1:0] reason_o,
  output logic                halt_o,
  output logic                busoff_evt_o,
  output logic                restarted_o,
  output logic                accept_o,
  output logic                warn_inc_o,
  output logic                passive_inc_o
);
  fc_state_e           state_q, state_d;
  logic [REASON_W-1:0] reason_q, reason_d;
  logic                halt_q, halt_d;
  logic                evt_bo_q, evt_bo_d;
  logic                evt_rs_q, evt_rs_d;

  assign accept_o = sample_i & ~halt_q & ~restart_i;

  assign warn_inc_o = accept_o & (state_q == FC_ACTIVE) & (new_state_i != FC_ACTIVE);
  assign passive_inc_o = accept_o &
                         ((state_q == FC_ACTIVE) | (state_q == FC_WARN)) &
                         ((new_state_i == FC_PASSIVE) | (new_state_i == FC_BUSOFF));

  always_comb begin
    state_d  = state_q;
    reason_d = reason_q;
    halt_d   = halt_q;
    evt_bo_d = 1'b0;
    evt_rs_d = 1'b0;
    if (restart_i) begin
      state_d  = FC_ACTIVE;
      reason_d = '0;
      halt_d   = 1'b0;
      evt_rs_d = 1'b1;
    end else if (accept_o) begin
      state_d  = new_state_i;
      reason_d = {ovf_i, src_i};
      halt_d   = (new_state_i == FC_BUSOFF) & ~auto_restart_i;
      evt_bo_d = (new_state_i == FC_BUSOFF) & (state_q != FC_BUSOFF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= FC_ACTIVE;
      reason_q <= '0;
      halt_q   <= 1'b0;
      evt_bo_q <= 1'b0;
      evt_rs_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      reason_q <= reason_d;
      halt_q   <= halt_d;
      evt_bo_q <= evt_bo_d;
      evt_rs_q <= evt_rs_d;
    end
  end

  assign state_o      = state_q;
  assign reason_o     = reason_q;
  assign halt_o       = halt_q;
  assign busoff_evt_o = evt_bo_q;
  assign restarted_o  = evt_rs_q;
endmodule

// File: rtl/canfc_satcnt.sv
module canfc_satcnt #(
  parameter int CNT_W = 16,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] inc_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum;
  logic             en;

  assign en  = |inc_i;
  assign sum = {1'b0, cnt_q} + {{(SUM_W-STEP_W){1'b0}}, inc_i};

  always_comb begin
    if (sum[CNT_W]) cnt_d = '1;
    else            cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/can_fault_monitor.sv
module can_fault_monitor
  import canfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FLAG_W-1:0]   flags_i,
  input  logic                sample_i,
  input  logic                err_irq_i,
  input  logic                auto_restart_i,
  input  logic                restart_i,
  output logic [1:0]          state_o,
  output logic [REASON_W-1:0] reason_o,
  output logic                halt_o,
  output logic                busoff_evt_o,
  output logic                restarted_o,
  output logic [CNT_W-1:0]    warn_cnt_o,
  output logic [CNT_W-1:0]    passive_cnt_o,
  output logic [CNT_W-1:0]    ovr_cnt_o
);
  fc_state_e        cls_state, cur_state;
  fc_src_e          cls_src;
  logic [INC_W-1:0] ovr_n;
  logic             ovf;
  logic             accept, warn_inc, passive_inc;
  logic [INC_W-1:0] inc_a [N_STATS];
  logic [CNT_W-1:0] cnt_a [N_STATS];

  canfc_classify i_classify (
    .flags_i (flags_i),
    .irq_i   (err_irq_i),
    .state_o (cls_state),
    .src_o   (cls_src),
    .ovr_n_o (ovr_n),
    .ovf_o   (ovf)
  );

  canfc_ctrl i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_i       (sample_i),
    .restart_i      (restart_i),
    .auto_restart_i (auto_restart_i),
    .new_state_i    (cls_state),
    .src_i          (cls_src),
    .ovf_i          (ovf),
    .state_o        (cur_state),
    .reason_o       (reason_o),
    .halt_o         (halt_o),
    .busoff_evt_o   (busoff_evt_o),
    .restarted_o    (restarted_o),
    .accept_o       (accept),
    .warn_inc_o     (warn_inc),
    .passive_inc_o  (passive_inc)
  );

  assign inc_a[0] = {1'b0, warn_inc};
  assign inc_a[1] = {1'b0, passive_inc};
  assign inc_a[2] = accept ? ovr_n : '0;

  for (genvar g = 0; g < N_STATS; g++) begin : g_stat
    canfc_satcnt #(.CNT_W(CNT_W), .STEP_W(INC_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (inc_a[g]),
      .cnt_o (cnt_a[g])
    );
  end

  assign state_o       = cur_state;
  assign warn_cnt_o    = cnt_a[0];
  assign passive_cnt_o = cnt_a[1];
  assign ovr_cnt_o     = cnt_a[2];
endmodule

// File: rtl/canfc_checker.sv
module canfc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       flags_i,
  input logic             sample_i,
  input logic             restart_i,
  input logic [1:0]       state_o,
  input logic             halt_o,
  input logic             busoff_evt_o,
  input logic             restarted_o,
  input logic [CNT_W-1:0] warn_cnt_o,
  input logic [CNT_W-1:0] passive_cnt_o,
  input logic [CNT_W-1:0] ovr_cnt_o
);
  assert_busoff_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && flags_i[5] && !halt_o && !restart_i) |=> (state_o == 2'd3));

  assert_warn_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((warn_cnt_o - $past(warn_cnt_o)) <= CNT_W'(1)));

  assert_cnt_mono_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovr_cnt_o >= $past(ovr_cnt_o)) && (passive_cnt_o >= $past(passive_cnt_o)));

  assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !restart_i) |=> ($stable(state_o) && $stable(warn_cnt_o) &&
                                $stable(passive_cnt_o) && $stable(ovr_cnt_o) && halt_o));

  assert_halt_busoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (state_o == 2'd3));

  assert_restart_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (state_o == 2'd0) && restarted_o && !halt_o);

  assert_busoff_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_evt_o |-> (state_o == 2'd3));
endmodule

bind can_fault_monitor canfc_checker #(.CNT_W(CNT_W)) i_canfc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .flags_i       (flags_i),
  .sample_i      (sample_i),
  .restart_i     (restart_i),
  .state_o       (state_o),
  .halt_o        (halt_o),
  .busoff_evt_o  (busoff_evt_o),
  .restarted_o   (restarted_o),
  .warn_cnt_o    (warn_cnt_o),
  .passive_cnt_o (passive_cnt_o),
  .ovr_cnt_o     (ovr_cnt_o)
);

// File: tb/test_can_fault_monitor.sv
module test_can_fault_monitor;
  localparam int CNT_W = 16;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       flags = '0;
  logic             sample = 1'b0, irq = 1'b0, autor = 1'b0, restart = 1'b0;
  logic [1:0]       state;
  logic [2:0]       reason;
  logic             halt, bo_evt, rs_evt;
  logic [CNT_W-1:0] wcnt, pcnt, ocnt;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_state, m_reason, m_halt, m_bo, m_rs, m_w, m_p, m_o;

  always #5 clk = ~clk;

  can_fault_monitor #(.CNT_W(CNT_W)) i_can_fault_monitor (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .sample_i(sample),
    .err_irq_i(irq), .auto_restart_i(autor), .restart_i(restart),
    .state_o(state), .reason_o(reason), .halt_o(halt),
    .busoff_evt_o(bo_evt), .restarted_o(rs_evt),
    .warn_cnt_o(wcnt), .passive_cnt_o(pcnt), .ovr_cnt_o(ocnt)
  );

  function automatic int pick_state(logic [7:0] f);
    if (f[5]) return 3;
    if (f[4] || f[3]) return 2;
    if (f[2] || f[1]) return 1;
    return 0;
  endfunction

  function automatic int pick_src(logic [7:0] f);
    if (f[5]) return 3;
    if (f[4]) return 1;
    if (f[3]) return 2;
    if (f[2]) return 1;
    if (f[1]) return 2;
    return 0;
  endfunction

  function automatic int sat(int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic chk(string req, string what, string note, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s %s: actual %0d expected %0d", req, what, note, act, exp);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_reason = 0; m_halt = 0; m_bo = 0; m_rs = 0;
    m_w = 0; m_p = 0; m_o = 0;
  endtask

  task automatic compare(string note, string ovr_req);
    chk("R1", "state", note, int'(state), m_state);
    chk("R2", "reason", note, int'(reason), m_reason);
    chk("R3", "warn_cnt", note, int'(wcnt), m_w);
    chk("R4", "passive_cnt", note, int'(pcnt), m_p);
    chk(ovr_req, "ovr_cnt", note, int'(ocnt), m_o);
    chk("R7", "halt", note, int'(halt), m_halt);
    chk("R10", "busoff_evt", note, int'(bo_evt), m_bo);
    chk("R9", "restarted", note, int'(rs_evt), m_rs);
  endtask

  // Called at a falling edge: drive, advance model one edge, compare at next falling edge.
  task automatic step(logic [7:0] f, bit s, bit q, bit a, bit r, string note,
                      string ovr_req = "R5");
    int ns, acc;
    flags = f; sample = s; irq = q; autor = a; restart = r;
    acc = (s && !m_halt && !r) ? 1 : 0;
    m_bo = 0; m_rs = 0;
    if (r) begin
      m_state = 0; m_reason = 0; m_halt = 0; m_rs = 1;
    end else if (acc == 1) begin
      ns = pick_state(f);
      if (m_state == 0 && ns != 0) m_w = sat(m_w + 1);
      if ((m_state == 0 || m_state == 1) && ns >= 2) m_p = sat(m_p + 1);
      if (q) m_o = sat(m_o + int'(f[6]) + int'(f[7]));
      m_bo = (ns == 3 && m_state != 3) ? 1 : 0;
      m_halt = (ns == 3 && !a) ? 1 : 0;
      m_reason = ((q && (f[6] || f[7])) ? 4 : 0) + pick_src(f);
      m_state = ns;
    end
    @(negedge clk);
    compare(note, ovr_req);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5eed_c0de);
    model_reset();
    repeat (3) @(negedge clk);
    compare("R11 reset values", "R5");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11 after release", "R5");

    step(8'h01, 1, 0, 0, 0, "R1 summary bit alone stays active");
    step(8'h04, 1, 0, 0, 0, "R3 active to warning tx");
    step(8'h02, 1, 0, 0, 0, "R2 warning rx no escalation");
    step(8'h10, 1, 0, 0, 0, "R4 warning to passive");
    step(8'h00, 1, 0, 0, 0, "R1 back to active");
    step(8'h18, 1, 0, 0, 0, "R4 active to passive counts both, tx wins");
    step(8'h20, 0, 1, 0, 0, "R12 no strobe holds");
    step(8'h00, 0, 0, 0, 0, "R12 idle hold");
    step(8'hC0, 1, 1, 0, 0, "R5 both overruns add two");
    step(8'h40, 1, 0, 0, 0, "R5 overrun without qualifier");
    step(8'h80, 1, 1, 0, 0, "R5 buffer 1 overrun");
    step(8'h00, 0, 0, 0, 1, "R9 restart from active");
    step(8'h00, 0, 0, 0, 0, "R9 event one cycle");
    step(8'h04, 1, 0, 0, 0, "R3 warning before bus-off");
    step(8'h3E, 1, 1, 0, 0, "R10 bus-off priority and event");
    step(8'h00, 1, 0, 0, 0, "R7 strobe ignored while halted");
    step(8'hC4, 1, 1, 0, 0, "R7 counters frozen while halted");
    step(8'h00, 0, 0, 0, 1, "R9 restart clears halt");
    step(8'h20, 1, 0, 1, 0, "R8 bus-off with auto-restart");
    step(8'h20, 1, 0, 1, 0, "R10 second bus-off no event");
    step(8'h08, 1, 0, 1, 0, "R8 strobes still classified");
    step(8'h00, 1, 0, 1, 0, "R8 back to active");
    step(8'h10, 1, 0, 0, 1, "R9 restart wins over strobe");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] f;
      bit s, q, a, r;
      f = 8'($urandom);
      if (($urandom % 4) != 0) f[5] = 1'b0;
      s = ($urandom % 4) != 0;
      q = $urandom % 2;
      a = ($urandom % 3) == 0;
      r = ($urandom % 16) == 0;
      step(f, s, q, a, r, "random R1 R2 R12");
    end

    step(8'h00, 0, 0, 0, 1, "R9 restart before saturation");
    for (int i = 0; i < (MAXC / 2) + 3; i++)
      step(8'hC0, 1, 1, 0, 0, "R6 overrun saturation", "R6");
    chk("R6", "ovr_cnt held", "end of run", int'(ocnt), MAXC);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule